// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of external Ethernet PHYs through a small 32-bit register window. Software writes one control word holding a direction, a 5-bit PHY address and a 5-bit register address. The block then sends a full Clause 22 management frame on MDC/MDIO. It clears the start bit it was launched with once the frame has gone out.

For a write, the 16-bit payload is taken from a separate data register. Software loads that register before it sets the write start bit. For a read, the block releases MDIO during turnaround and data, and shifts in the PHY's reply. It then places the 16-bit result in the low half of the control word, in the same cycle that the read start bit clears. MDC is a divided copy of the system clock and stays low while the block is idle.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word and the data register both read as zero, MDC is low and MDIO output enable is low.
- R2: Offset 0 is the control word: bit 27 starts a write, bit 26 starts a read, bits 25:21 hold the register address, bits 20:16 hold the PHY address, bits 15:0 hold the read result and bits 31:28 read as zero. Offset 4 is the data register: only bits 15:0 are kept and bits 31:16 read as zero.
- R3: Every frame has 64 bits, sent MSB first in this order: 32 ones, start 01, opcode (10 for a read, 01 for a write), PHY address, register address, a 2-bit turnaround, then 16 data bits.
- R4: In a write frame the turnaround is driven as 10, the data bits equal bits 15:0 of the data register, and the output enable stays high for all 64 bits.
- R5: In a read frame the output enable is high for bits 0 to 45 and low for bits 46 to 63. MDIO is sampled at each rising MDC edge of bits 48 to 63, MSB first, and the 16-bit result appears in control bits 15:0 when bit 26 clears.
- R6: The start bit reads set from the cycle after the launching write and clears after exactly 64 MDC periods, which is 64*CLK_DIV clock cycles.
- R7: MDC has a period of CLK_DIV clocks with equal high and low halves. MDIO changes only on falling MDC edges, and MDC is low whenever no transaction is running.
- R8: A control write while a transaction is running is ignored: the frame in progress and the address fields are unchanged, and no further frame follows.
- R9: A control write with both start bits set launches a read. Bit 26 reads set and bit 27 reads clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift register shows up within one frame at the ports in three ways. The MDIO bits seen at the rising MDC edges do not match the arithmetically built frame. The output enable drops at the wrong bit. The start bit clears on a cycle other than the 64*CLK_DIV-th. A wrong receive path shows up as soon as the start bit clears, because the returned value differs from the pattern the PHY model drove. A stuck busy state or a bad divider shows up within a few MDC periods, as MDC activity while idle or as a wrong rise-to-rise spacing.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int CLK_DIV = 20,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int CW       = $clog2(HALF + 1);
  localparam int NBITS    = 64;
  localparam int IW       = $clog2(NBITS);
  localparam int RX_FIRST = 48;
  localparam int REL_BIT  = 46;

  logic          wr_go, rd_go;
  logic [4:0]    reg_a, phy_a;
  logic [15:0]   rd_val, wr_val, rx;
  logic [NBITS-1:0] frame;
  logic [IW-1:0] idx;
  logic [CW-1:0] div_cnt;
  logic          mdc_q;
  logic          busy, ctrl_wr, data_wr, launch, want_rd;
  logic          unused_bits;

  assign busy    = wr_go | rd_go;
  assign ctrl_wr = bus_we && bus_addr == ADDR_W'(0);
  assign data_wr = bus_we && bus_addr == ADDR_W'(4);
  assign want_rd = bus_wdata[26];
  assign launch  = ctrl_wr && !busy && (bus_wdata[26] | bus_wdata[27]);
  assign unused_bits = ^bus_wdata[31:28];

  assign mdc     = mdc_q;
  assign mdio_o  = frame[NBITS-1];
  assign mdio_oe = busy && !(rd_go && idx >= IW'(REL_BIT));

  always_comb begin
    if (bus_addr == ADDR_W'(0))
      bus_rdata = {4'b0, wr_go, rd_go, reg_a, phy_a, rd_val};
    else if (bus_addr == ADDR_W'(4))
      bus_rdata = {16'b0, wr_val};
    else
      bus_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_go <= 1'b0; rd_go <= 1'b0;
      reg_a <= '0; phy_a <= '0;
      rd_val <= '0; wr_val <= '0; rx <= '0;
      frame <= '0; idx <= '0; div_cnt <= '0; mdc_q <= 1'b0;
    end else begin
      if (data_wr) wr_val <= bus_wdata[15:0];
      if (!busy) begin
        if (ctrl_wr) begin
          reg_a <= bus_wdata[25:21];
          phy_a <= bus_wdata[20:16];
        end
        if (launch) begin
          rd_go   <= want_rd;
          wr_go   <= !want_rd;
          frame   <= {32'hFFFF_FFFF, 2'b01, want_rd ? 2'b10 : 2'b01,
                      bus_wdata[20:16], bus_wdata[25:21],
                      want_rd ? 18'h0 : {2'b10, wr_val}};
          idx     <= '0;
          div_cnt <= '0;
          mdc_q   <= 1'b0;
        end
      end else if (div_cnt == CW'(HALF - 1)) begin
        div_cnt <= '0;
        mdc_q   <= ~mdc_q;
        if (!mdc_q) begin
          if (rd_go && idx >= IW'(RX_FIRST)) rx <= {rx[14:0], mdio_i};
        end else if (idx == IW'(NBITS - 1)) begin
          wr_go <= 1'b0;
          rd_go <= 1'b0;
          if (rd_go) rd_val <= rx;
        end else begin
          idx   <= idx + 1'b1;
          frame <= {frame[NBITS-2:0], 1'b0};
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       wr_go,
  input logic       rd_go,
  input logic [4:0] phy_a,
  input logic [4:0] reg_a
);
  // R7
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go || rd_go) |-> !mdc);
  // R7
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go || rd_go) && $past(wr_go || rd_go) && !$stable(mdio_o) |-> $fell(mdc));
  // R9
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_go, rd_go}));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go || rd_go) && $past(wr_go || rd_go) |-> $stable({phy_a, reg_a}));
  // R4
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> mdio_oe);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go || rd_go) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .wr_go(wr_go), .rd_go(rd_go), .phy_a(phy_a), .reg_a(reg_a)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int DIV = 4;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;

  logic [63:0] cap, oe_cap;
  logic [15:0] resp;
  int          mon_cnt = 0;
  time         t_r0, t_r1, t_f0;

  always #10 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV), .ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (mon_cnt < 64) begin
      cap[63-mon_cnt]    = mdio_o;
      oe_cap[63-mon_cnt] = mdio_oe;
    end
    if (mon_cnt == 0) t_r0 = $time;
    if (mon_cnt == 1) t_r1 = $time;
    mon_cnt = mon_cnt + 1;
  end

  always @(negedge mdc) begin
    if (mon_cnt == 1) t_f0 = $time;
    if (mon_cnt >= 48 && mon_cnt <= 63) mdio_i = resp[63-mon_cnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_txn(input logic [31:0] ctrl, output int cyc);
    logic [31:0] d;
    mon_cnt = 0;
    cyc = 0;
    bus_write(3'd0, ctrl);
    bus_addr = 3'd0;
    for (int g = 0; g < 20000; g++) begin
      #1 d = bus_rdata;
      if (d[27:26] == 2'b00) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit rd, input bit wr, input logic [4:0] phy, input logic [4:0] rg);
    return {4'b0, wr, rd, rg, phy, 16'h0};
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] expf;
    int cyc;
    resp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(3'd0, d);
    chk(d == 32'h0, "R1 ctrl reset", d, 0);
    bus_read(3'd4, d);
    chk(d == 32'h0, "R1 data reset", d, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe reset", {mdc, mdio_oe}, 0);

    bus_write(3'd4, 32'hFFFF_1234);
    bus_read(3'd4, d);
    chk(d == 32'h0000_1234, "R2 data reg width", d, 32'h1234);

    for (int p = 0; p < 32; p++) begin
      logic [4:0] rg;
      rg = 5'((p * 5 + 3) & 31);
      resp = 16'((p * 16'h0913) ^ 16'hC35A);
      run_txn(ctrl_word(1'b1, 1'b0, 5'(p), rg), cyc);
      expf = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(p), rg, 18'h0};
      chk(cap[63:18] == expf[63:18], "R3 read header", cap, expf);
      chk(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 read release", oe_cap, {46'h3FFF_FFFF_FFFF, 18'h0});
      chk(cyc == FRAME_CYC, "R6 read duration", 64'(cyc), 64'(FRAME_CYC));
      bus_read(3'd0, d);
      chk(d == {6'b0, rg, 5'(p), resp}, "R5 R2 read result", d, {6'b0, rg, 5'(p), resp});
    end

    chk(t_r1 - t_r0 == DIV * 20, "R7 mdc period", 64'(t_r1 - t_r0), 64'(DIV * 20));
    chk(t_f0 - t_r0 == DIV * 10, "R7 mdc high time", 64'(t_f0 - t_r0), 64'(DIV * 10));

    for (int k = 0; k < 16; k++) begin
      logic [15:0] wd;
      logic [4:0]  ph, rg;
      wd = 16'((k * 16'h1111) ^ 16'h8001);
      ph = 5'(31 - k);
      rg = 5'(k * 2);
      bus_write(3'd4, {16'hABCD, wd});
      run_txn(ctrl_word(1'b0, 1'b1, ph, rg), cyc);
      expf = {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd};
      chk(cap == expf, "R3 R4 write frame", cap, expf);
      chk(oe_cap == 64'hFFFF_FFFF_FFFF_FFFF, "R4 write drives", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
      chk(cyc == FRAME_CYC, "R6 write duration", 64'(cyc), 64'(FRAME_CYC));
    end

    repeat (3 * DIV) begin
      @(negedge clk);
      chk(mdc == 1'b0, "R7 idle mdc low", mdc, 0);
    end

    resp = 16'h5AA5;
    mon_cnt = 0;
    bus_write(3'd0, ctrl_word(1'b1, 1'b0, 5'd3, 5'd7));
    repeat (20) @(negedge clk);
    bus_write(3'd0, ctrl_word(1'b0, 1'b1, 5'd9, 5'd9));
    bus_read(3'd0, d);
    chk(d[27:16] == {2'b01, 5'd7, 5'd3}, "R8 fields kept while busy", d[27:16], {2'b01, 5'd7, 5'd3});
    for (int g = 0; g < 20000 && d[27:26] != 2'b00; g++) bus_read(3'd0, d);
    expf = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd7, 18'h0};
    chk(cap[63:18] == expf[63:18], "R8 frame unchanged", cap, expf);
    chk(d[15:0] == 16'h5AA5, "R8 read result", d[15:0], 16'h5AA5);
    repeat (2 * FRAME_CYC) @(negedge clk);
    chk(mon_cnt == 64, "R8 no second frame", 64'(mon_cnt), 64);

    resp = 16'h0F0F;
    mon_cnt = 0;
    bus_write(3'd0, ctrl_word(1'b1, 1'b1, 5'd17, 5'd21));
    bus_read(3'd0, d);
    chk(d[27:26] == 2'b01, "R9 read wins", d[27:26], 2'b01);
    for (int g = 0; g < 20000 && d[27:26] != 2'b00; g++) bus_read(3'd0, d);
    chk(cap[29:28] == 2'b10, "R9 read opcode", cap[29:28], 2'b10);
    chk(d[15:0] == 16'h0F0F, "R9 read result", d[15:0], 16'h0F0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule